// File: doc/BRIEF.md
# SD SPI Block Write Transmitter

This block handles the data phase of a card write in SPI mode, once the write command has already been issued elsewhere. A start pulse selects either a one-block write or a multi-block write with a block count. For every block it sends a filler byte and a start token, then the block bytes taken from a valid/ready byte stream, then a 16-bit CRC. It then reads back bytes until the card's data-response token appears and decodes it. After an accepted block it polls until the card releases the busy state.

All traffic goes through a byte-exchange port. The block raises a request carrying the byte to send and holds it until the link returns an acknowledge with the byte that was clocked in at the same time. Read-only exchanges send 0xFF. When every block of a multi-block write succeeds, the block sends a closing filler and stop token and waits for busy to clear once more. A failed block ends the transfer at once. Each transfer ends with a one-cycle done pulse. Two flags report the outcome: one for a rejected or missing response, one for a busy timeout.

Top module: `sdw_block_tx`

## Requirements
- R1: Every block starts with the byte 0xFF and then a start token: 0xFE when the transfer was started in single mode (multi=0), and 0xFC in multi mode (multi=1).
- R2: After the token, exactly BLK_BYTES bytes are sent in the order they are accepted on din (one byte per din_valid/din_ready handshake). Then the CRC16 of those bytes follows, high byte first. The CRC uses polynomial 0x1021, a zero seed, MSB-first bit order and no final inversion.
- R3: After the CRC the block sends up to RESP_TRIES (8) bytes of 0xFF. The response token is the first returned byte whose bit 4 is 0. If none of those bytes has bit 4 clear, the transfer ends with err_resp.
- R4: If the low five bits of the response token equal 0x05, the block is accepted. Any other value, including 0x0B and 0x0D, ends the transfer with err_resp and no further exchange.
- R5: After an accepted block, bytes of 0xFF are sent and the returned bytes polled. The wait ends at the first returned 0xFF, but the first poll never counts. If BUSY_LIMIT polls pass without that, the transfer ends with err_timeout.
- R6: In multi mode, once the last block has passed its busy wait, the block sends 0xFF and then 0xFD, followed by the same busy wait as R5. In single mode no stop token is ever sent.
- R7: Single mode writes exactly one block whatever blk_count holds. Multi mode writes blk_count blocks, and a count of zero is treated as one.
- R8: done is high for exactly one cycle at the end of every transfer. err_resp and err_timeout are updated with it, never both set, and held until the next accepted start.
- R9: start is ignored while busy is high. The byte stream and mode of the running transfer stay unchanged.
- R10: After reset, busy, done, xfer_req, din_ready, err_resp and err_timeout are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer when idle |
| multi | input | 1 | 1 selects multi-block mode, sampled with start |
| blk_count | input | CNT_W | Number of blocks in multi mode, sampled with start |
| din_data | input | 8 | Block data byte |
| din_valid | input | 1 | din_data holds a byte |
| din_ready | output | 1 | Block takes din_data this cycle if din_valid |
| xfer_req | output | 1 | Byte exchange requested, held until xfer_ack |
| xfer_tx | output | 8 | Byte to send, stable while xfer_req is high |
| xfer_ack | input | 1 | Exchange complete, xfer_rx valid |
| xfer_rx | input | 8 | Byte received during the exchange |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_resp | output | 1 | Response rejected or not found |
| err_timeout | output | 1 | Busy wait exceeded its limit |

## Verification
A scripted card model answers each exchange from a queue. The main path is run with a response token arriving at once, after idle bytes, and only on the last allowed try. Together these separate a correct search window from one that is off by one. Busy answers are tried as a leading 0xFF, which must not end the wait, and as a release on the last allowed poll. The stop-token wait gets its own timeout. Rejections with code 0x0B, code 0x0D and no token at all check that a multi-block transfer stops without a stop token and that the two error flags stay apart.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

  localparam logic [7:0]  BYTE_IDLE   = 8'hFF;
  localparam logic [7:0]  TOK_SINGLE  = 8'hFE;
  localparam logic [7:0]  TOK_MULTI   = 8'hFC;
  localparam logic [7:0]  TOK_STOP    = 8'hFD;
  localparam logic [4:0]  RESP_ACCEPT = 5'h05;
  localparam logic [15:0] CRC_POLY    = 16'h1021;

  typedef enum logic [3:0] {
    S_IDLE, S_FILL, S_TOKEN, S_DATA, S_CRC_HI, S_CRC_LO,
    S_RESP, S_BUSY, S_STOP_FILL, S_STOP_TOK, S_STOP_BUSY
  } wr_state_t;

  // one byte of CRC16, polynomial 0x1021, MSB first
  function automatic logic [15:0] crc16_next(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  // a response byte is a token when bit 4 is clear
  function automatic logic is_token(input logic [7:0] b);
    return ~b[4];
  endfunction

endpackage

// File: rtl/sdw_crc16.sv
module sdw_crc16
  import sdw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  always_ff @(posedge clk) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= crc16_next(crc, din);
  end

  // R2: seed and update never requested together
  crc_clr_en_chk: assert property (@(posedge clk) disable iff (!rst_n) !(clr && en));

endmodule

// File: rtl/sdw_lim_ctr.sv
module sdw_lim_ctr #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);

  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == W'(LIMIT - 1));

  // R3 R5: a window counter is never stepped past its limit
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !last);

endmodule

// File: rtl/sdw_block_tx.sv
module sdw_block_tx
  import sdw_pkg::*;
#(
  parameter int unsigned BLK_BYTES  = 512,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned BUSY_LIMIT = 3000000,
  parameter int unsigned RESP_TRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             multi,
  input  logic [CNT_W-1:0] blk_count,
  input  logic [7:0]       din_data,
  input  logic             din_valid,
  output logic             din_ready,
  output logic             xfer_req,
  output logic [7:0]       xfer_tx,
  input  logic             xfer_ack,
  input  logic [7:0]       xfer_rx,
  output logic             busy,
  output logic             done,
  output logic             err_resp,
  output logic             err_timeout
);

  wr_state_t        st;
  logic             req_q;
  logic [7:0]       tx_q;
  logic             mode_multi;
  logic [CNT_W-1:0] blocks_left;
  logic             polled;
  logic             done_q, e_resp_q, e_to_q;
  logic [15:0]      crc;
  logic [7:0]       nxt_tx;

  // named events
  wire ack_ev     = req_q & xfer_ack;
  wire issue_ok   = !req_q && (st != S_IDLE) && ((st != S_DATA) || din_valid);
  wire din_take   = (st == S_DATA) && !req_q && din_valid;
  wire rx_token   = is_token(xfer_rx);
  wire rx_accept  = (xfer_rx[4:0] == RESP_ACCEPT);
  wire rx_ready   = polled && (xfer_rx == BYTE_IDLE);
  wire in_busy    = (st == S_BUSY) || (st == S_STOP_BUSY);
  wire byte_last, resp_last, busy_last;

  wire fail_resp  = (st == S_RESP) && ack_ev &&
                    ((rx_token && !rx_accept) || (!rx_token && resp_last));
  wire resp_good  = (st == S_RESP) && ack_ev && rx_token && rx_accept;
  wire fail_to    = in_busy && ack_ev && !rx_ready && busy_last;
  wire blk_ok     = (st == S_BUSY) && ack_ev && rx_ready;
  wire stop_ok    = (st == S_STOP_BUSY) && ack_ev && rx_ready;
  wire blk_final  = blk_ok && (blocks_left == '0);
  wire finish     = fail_resp || fail_to || stop_ok || (blk_final && !mode_multi);
  wire enter_busy = resp_good || ((st == S_STOP_TOK) && ack_ev);
  wire data_start = (st == S_TOKEN) && ack_ev;

  sdw_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(data_start), .en(din_take),
    .din(din_data), .crc(crc)
  );

  sdw_lim_ctr #(.LIMIT(BLK_BYTES)) u_byte_ctr (
    .clk(clk), .rst_n(rst_n), .clr(data_start),
    .inc((st == S_DATA) && ack_ev && !byte_last), .last(byte_last)
  );

  sdw_lim_ctr #(.LIMIT(RESP_TRIES)) u_resp_ctr (
    .clk(clk), .rst_n(rst_n), .clr((st == S_CRC_LO) && ack_ev),
    .inc((st == S_RESP) && ack_ev && !rx_token && !resp_last), .last(resp_last)
  );

  sdw_lim_ctr #(.LIMIT(BUSY_LIMIT)) u_busy_ctr (
    .clk(clk), .rst_n(rst_n), .clr(enter_busy),
    .inc(in_busy && ack_ev && !rx_ready && !busy_last), .last(busy_last)
  );

  always_comb begin
    unique case (st)
      S_TOKEN:    nxt_tx = mode_multi ? TOK_MULTI : TOK_SINGLE;
      S_DATA:     nxt_tx = din_data;
      S_CRC_HI:   nxt_tx = crc[15:8];
      S_CRC_LO:   nxt_tx = crc[7:0];
      S_STOP_TOK: nxt_tx = TOK_STOP;
      default:    nxt_tx = BYTE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      req_q       <= 1'b0;
      tx_q        <= BYTE_IDLE;
      mode_multi  <= 1'b0;
      blocks_left <= '0;
      polled      <= 1'b0;
      done_q      <= 1'b0;
      e_resp_q    <= 1'b0;
      e_to_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st == S_IDLE && start) begin
        mode_multi  <= multi;
        blocks_left <= (multi && blk_count != '0) ? blk_count - 1'b1 : '0;
        e_resp_q    <= 1'b0;
        e_to_q      <= 1'b0;
        st          <= S_FILL;
      end
      if (issue_ok) begin
        req_q <= 1'b1;
        tx_q  <= nxt_tx;
      end
      if (enter_busy)           polled <= 1'b0;
      else if (in_busy && ack_ev) polled <= 1'b1;
      if (ack_ev) begin
        req_q <= 1'b0;
        if (finish) begin
          st       <= S_IDLE;
          done_q   <= 1'b1;
          e_resp_q <= fail_resp;
          e_to_q   <= fail_to;
        end else begin
          unique case (st)
            S_FILL:      st <= S_TOKEN;
            S_TOKEN:     st <= S_DATA;
            S_DATA:      if (byte_last) st <= S_CRC_HI;
            S_CRC_HI:    st <= S_CRC_LO;
            S_CRC_LO:    st <= S_RESP;
            S_RESP:      if (resp_good) st <= S_BUSY;
            S_BUSY:      if (blk_ok) begin
                           if (blk_final) st <= S_STOP_FILL;
                           else begin
                             blocks_left <= blocks_left - 1'b1;
                             st          <= S_FILL;
                           end
                         end
            S_STOP_FILL: st <= S_STOP_TOK;
            S_STOP_TOK:  st <= S_STOP_BUSY;
            default:     st <= st;
          endcase
        end
      end
    end
  end

  assign din_ready   = (st == S_DATA) && !req_q;
  assign xfer_req    = req_q;
  assign xfer_tx     = tx_q;
  assign busy        = (st != S_IDLE);
  assign done        = done_q;
  assign err_resp    = e_resp_q;
  assign err_timeout = e_to_q;

  // R2: an open request holds its byte until acknowledged
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_resp && err_timeout));

  // R4: a rejected response leaves no exchange open afterwards
  reject_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_resp |=> (!xfer_req && !busy));

  // R6: stop token only belongs to multi mode
  stop_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP_TOK) |-> mode_multi);

  // R9: a start during a transfer leaves its mode alone
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> $stable(mode_multi));

endmodule

// File: tb/sim_sdw_block_tx.sv
`timescale 1ns/1ps
module sim_sdw_block_tx;

  localparam int BLK = 8;
  localparam int CW  = 4;
  localparam int BL  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, multi = 1'b0;
  logic [CW-1:0] blk_count = '0;
  logic [7:0] din_data = 8'h00;
  logic din_valid = 1'b0;
  logic din_ready, xfer_req, xfer_ack = 1'b0, busy, done, err_resp, err_timeout;
  logic [7:0] xfer_tx, xfer_rx = 8'hFF;

  int checks = 0, fails = 0;
  int mis = 0, mis_act = 0, mis_exp = 0;
  logic [7:0] exp_tx[$], exp_rx[$], din_q[$];
  bit prev_take = 0;

  always #2 clk = ~clk;

  sdw_block_tx #(.BLK_BYTES(BLK), .CNT_W(CW), .BUSY_LIMIT(BL), .RESP_TRIES(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .multi(multi), .blk_count(blk_count),
    .din_data(din_data), .din_valid(din_valid), .din_ready(din_ready),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
    .busy(busy), .done(done), .err_resp(err_resp), .err_timeout(err_timeout));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  // byte-wise CRC formula, independent of a bit loop
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] x;
    x = {8'h00, c[15:8] ^ b};
    x = x ^ (x >> 4);
    return (c << 8) ^ (x << 12) ^ (x << 5) ^ x;
  endfunction

  // data source
  always @(negedge clk) begin
    if (prev_take) void'(din_q.pop_front());
    din_valid = (din_q.size() > 0);
    din_data  = din_valid ? din_q[0] : 8'h00;
    prev_take = din_ready && din_valid;
  end

  // monitor / card model: pops the scoreboard on every exchange
  always @(negedge clk) begin
    if (!rst_n) xfer_ack = 1'b0;
    else if (xfer_ack) xfer_ack = 1'b0;
    else if (xfer_req) begin
      if (exp_tx.size() == 0) begin
        if (mis == 0) begin mis_act = xfer_tx; mis_exp = 'h100; end
        mis++;
        xfer_rx = 8'hFF;
      end else begin
        logic [7:0] e;
        e = exp_tx.pop_front();
        if (xfer_tx !== e) begin
          if (mis == 0) begin mis_act = xfer_tx; mis_exp = e; end
          mis++;
        end
        xfer_rx = exp_rx.pop_front();
      end
      xfer_ack = 1'b1;
    end
  end

  task automatic ex(input logic [7:0] t, input logic [7:0] r);
    exp_tx.push_back(t); exp_rx.push_back(r);
  endtask

  task automatic rd(input logic [7:0] r);
    ex(8'hFF, r);
  endtask

  task automatic blk(input logic [7:0] tok, input int seed);
    logic [15:0] c;
    c = 16'h0000;
    ex(8'hFF, 8'hFF);
    ex(tok, 8'hFF);
    for (int i = 0; i < BLK; i++) begin
      logic [7:0] b;
      b = 8'(seed * 37 + i * 11 + 3);
      din_q.push_back(b);
      ex(b, 8'hFF);
      c = ref_crc(c, b);
    end
    ex(c[15:8], 8'hFF);
    ex(c[7:0], 8'hFF);
  endtask

  task automatic run(input string req, input bit m, input int cnt, input bit poke,
                     input bit exp_r, input bit exp_t);
    int cyc;
    mis = 0;
    @(negedge clk);
    start = 1'b1; multi = m; blk_count = CW'(cnt);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 6) begin start = 1'b1; multi = ~m; blk_count = 4'd3; end
      if (poke && cyc == 7) start = 1'b0;
    end
    chk(cyc < 3000, req, "watchdog: done seen", cyc, 3000);
    chk(mis == 0, req, "byte stream", mis_act, mis_exp);
    chk(exp_tx.size() == 0, req, "exchanges left over", exp_tx.size(), 0);
    chk(din_q.size() == 0, req, "data bytes left", din_q.size(), 0);
    chk(err_resp == exp_r, "R8", {req, " err_resp"}, err_resp, exp_r);
    chk(err_timeout == exp_t, "R8", {req, " err_timeout"}, err_timeout, exp_t);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done single cycle", done, 0);
    chk(err_resp == exp_r && err_timeout == exp_t, "R8", "flags held",
        {err_resp, err_timeout}, {exp_r, exp_t});
    exp_tx.delete(); exp_rx.delete(); din_q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk({busy, done, xfer_req, din_ready, err_resp, err_timeout} == 6'b0, "R10",
        "reset outputs", {busy, done, xfer_req, din_ready, err_resp, err_timeout}, 0);

    // R1 R2 R7 R9: single, count ignored, mid-run start ignored
    blk(8'hFE, 1); rd(8'hE5); rd(8'h00); rd(8'hFF);
    run("R1 R2 R7 R9 single", 1'b0, 5, 1'b1, 1'b0, 1'b0);

    // R3 R5 R6: two blocks, late token, leading 0xFF in busy, stop with wait
    blk(8'hFC, 2); rd(8'hFF); rd(8'hFF); rd(8'hE5); rd(8'hFF); rd(8'h00); rd(8'hFF);
    blk(8'hFC, 3); rd(8'hE5); rd(8'h00); rd(8'hFF);
    ex(8'hFF, 8'hFF); ex(8'hFD, 8'hFF); rd(8'h00); rd(8'h00); rd(8'hFF);
    run("R3 R5 R6 multi2", 1'b1, 2, 1'b0, 1'b0, 1'b0);

    // R4: CRC-error code in multi mode, no stop token
    blk(8'hFC, 4); rd(8'hEB);
    run("R4 code 0x0B", 1'b1, 2, 1'b0, 1'b1, 1'b0);

    // R4: write-error code
    blk(8'hFE, 5); rd(8'hFF); rd(8'hED);
    run("R4 code 0x0D", 1'b0, 1, 1'b0, 1'b1, 1'b0);

    // R3: no token within eight bytes
    blk(8'hFE, 6);
    for (int i = 0; i < 8; i++) rd((i % 2) ? 8'h10 : 8'hFF);
    run("R3 no token", 1'b0, 1, 1'b0, 1'b1, 1'b0);

    // R3: token on the eighth try
    blk(8'hFE, 7);
    for (int i = 0; i < 7; i++) rd(8'hFF);
    rd(8'h05); rd(8'hFF); rd(8'h00); rd(8'hFF);
    run("R3 last try", 1'b0, 1, 1'b0, 1'b0, 1'b0);

    // R5: busy never released
    blk(8'hFE, 8); rd(8'hE5);
    for (int i = 0; i < BL; i++) rd(8'h00);
    run("R5 busy timeout", 1'b0, 1, 1'b0, 1'b0, 1'b1);

    // R5: release on the last allowed poll
    blk(8'hFE, 9); rd(8'hE5);
    for (int i = 0; i < BL - 1; i++) rd(8'h00);
    rd(8'hFF);
    run("R5 last poll", 1'b0, 1, 1'b0, 1'b0, 1'b0);

    // R6 R7: multi with count zero, stop wait times out after a leading 0xFF
    blk(8'hFC, 10); rd(8'hE5); rd(8'h00); rd(8'hFF);
    ex(8'hFF, 8'hFF); ex(8'hFD, 8'hFF); rd(8'hFF);
    for (int i = 0; i < BL - 1; i++) rd(8'h00);
    run("R6 R7 stop timeout", 1'b1, 0, 1'b0, 1'b0, 1'b1);

    // R8: a clean run after an error clears the flags
    blk(8'hFE, 11); rd(8'hE5); rd(8'h00); rd(8'hFF);
    run("R8 clear", 1'b0, 1, 1'b0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule